// File: doc/BRIEF.md
# Modem Line Status and Scratch Register Block

This block watches four active-low handshake inputs of a serial port: clear-to-send, data-set-ready, ring indicator and carrier-detect. Each external line goes through a two-stage synchronizer. The block then converts the line to an "asserted" level, where a low pin counts as 1. It shows these levels in the upper nibble of an 8-bit read-only status word.

The lower nibble holds sticky event flags. The ring flag records only the ring line going back from low to high. Each of the other three flags records a change in either direction. All four flags clear when the status word is read. If a new event arrives in the same cycle as that read, the event is kept.

A loopback control takes the four levels from a modem-control byte instead of the pins. An OR of the event flags drives an output for an interrupt controller. The block also holds a separate 8-bit scratch byte that software can read and write, and that byte has no side effects.

Top module: `mdm_status_regs`

## Requirements
- R1: With loopback off, status bits 4, 5, 6 and 7 read as the inverse of the synchronized clear-to-send, data-set-ready, ring and carrier-detect pins. A pin change first shows in the status word after the second rising clock edge.
- R2: Flag bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier-detect) set on any change of their line's level. A pin change sets the flag at the third rising edge.
- R3: Flag bit 2 sets only when the ring pin goes from low to high, which means status bit 6 falls from 1 to 0. A ring pin going from high to low leaves bit 2 at 0.
- R4: A read strobe to the status address (0) clears bits 3:0 at the clock edge and leaves bits 7:4 unchanged. A read of any other address clears nothing.
- R5: When a line event and a status read fall in the same cycle, the read returns the old flag value and the flag is 1 afterwards.
- R6: With loopback on, status bit 5 follows control bit 0, bit 4 follows control bit 1, bit 6 follows control bit 2 and bit 7 follows control bit 3, in the same cycle. The pins are then ignored, and changes of these levels set the flags as pin changes would.
- R7: After reset the status word and the scratch byte are 0. Read-data bits 31:8 are always 0, and an unmapped address reads as 0.
- R8: The scratch byte at address 1 stores a written value and returns it on read. Accessing it has no effect on the status word.
- R9: `delta_pending` is 1 exactly when any of status bits 3:0 is 1.
- R10: A write to the status address changes neither the flags nor the levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| pin_dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| pin_ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| pin_dcd_n | input | 1 | Carrier-detect pin, active low, asynchronous |
| loop_en | input | 1 | Loopback select, synchronous to clk |
| loop_ctl | input | 4 | Modem-control bits used as line levels in loopback |
| reg_addr | input | 3 | Register word address (0 status, 1 scratch) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; a strobe to address 0 clears the flags |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| delta_pending | output | 1 | OR of the four event flags |

## Verification
The assertions assume that `loop_en`, `loop_ctl` and the register strobes are synchronous to `clk`. They also assume that the pins stay high (idle) through reset, so that no change is seen when reset is released. The bench drives every input at the falling edge and keeps the pins high during reset. Before reading, it waits long enough for a pin change to travel through the synchronizer. The one exception is the step that checks pin timing edge by edge.

// File: rtl/mdm_stat_pkg.sv
package mdm_stat_pkg;
  localparam int NLINES = 4;
  // line index = position in each nibble of the status word
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;
  // lines whose flag records only the deassertion (pin low-to-high)
  localparam logic [NLINES-1:0] DEASSERT_ONLY = 4'b0100;

  // control byte bits to line order: dsr<-0, cts<-1, ri<-2, dcd<-3
  function automatic logic [NLINES-1:0] loop_map(input logic [3:0] ctl);
    loop_map = {ctl[3], ctl[2], ctl[0], ctl[1]};
  endfunction

  function automatic logic [7:0] pack_status(input logic [NLINES-1:0] lvl,
                                             input logic [NLINES-1:0] flg);
    pack_status = {lvl, flg};
  endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= RST_VAL;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/mdm_edge_det.sv
module mdm_edge_det #(
  parameter int NL = 4,
  parameter logic [NL-1:0] FALL_ONLY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] level,
  output logic [NL-1:0] evt
);
  logic [NL-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else prev <= level;
  end

  genvar i;
  generate
    for (i = 0; i < NL; i++) begin : g_line
      if (FALL_ONLY[i]) begin : g_fall
        assign evt[i] = prev[i] & ~level[i];
      end else begin : g_any
        assign evt[i] = prev[i] ^ level[i];
      end
    end
  endgenerate
endmodule

// File: rtl/mdm_flags.sv
module mdm_flags #(
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] set_i,
  input  logic          clr_i,
  output logic [NL-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else if (clr_i) flags <= set_i;
    else flags <= flags | set_i;
  end

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flags & $past(set_i)) == $past(set_i)));
  assert_clear_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i == '0) |=> (flags == '0));
  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && set_i == '0) |=> $stable(flags));
endmodule

// File: rtl/mdm_status_regs.sv
module mdm_status_regs
  import mdm_stat_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 0,
  parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_cts_n,
  input  logic              pin_dsr_n,
  input  logic              pin_ri_n,
  input  logic              pin_dcd_n,
  input  logic              loop_en,
  input  logic [3:0]        loop_ctl,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  output logic              delta_pending
);
  logic [NLINES-1:0] pins_n, pins_sync_n, line_lvl, line_evt, flags;
  logic [7:0]        scratch, status_word;
  logic              status_rd, scratch_wr;

  assign pins_n = {pin_dcd_n, pin_ri_n, pin_dsr_n, pin_cts_n};

  mdm_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_n), .q(pins_sync_n));

  assign line_lvl = loop_en ? loop_map(loop_ctl) : ~pins_sync_n;

  mdm_edge_det #(.NL(NLINES), .FALL_ONLY(DEASSERT_ONLY)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(line_lvl), .evt(line_evt));

  assign status_rd = reg_rd && (reg_addr == STATUS_ADDR);

  mdm_flags #(.NL(NLINES)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(line_evt), .clr_i(status_rd), .flags(flags));

  assign scratch_wr = reg_wr && (reg_addr == SCRATCH_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scratch <= '0;
    else if (scratch_wr) scratch <= reg_wdata;
  end

  assign status_word   = pack_status(line_lvl, flags);
  assign delta_pending = |flags;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == STATUS_ADDR) reg_rdata[7:0] = status_word;
    else if (reg_addr == SCRATCH_ADDR) reg_rdata[7:0] = scratch;
  end

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:8] == '0);
  assert_loop_mapping_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && reg_addr == STATUS_ADDR) |->
      (reg_rdata[4] == loop_ctl[1] && reg_rdata[5] == loop_ctl[0] &&
       reg_rdata[6] == loop_ctl[2] && reg_rdata[7] == loop_ctl[3]));
  assert_ri_trailing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt[LN_RI] |-> !line_lvl[LN_RI]);
  assert_pending_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_pending) |-> $past(|line_evt));
  assert_scratch_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scratch_wr |=> (scratch == $past(reg_wdata)));
endmodule

// File: tb/mdm_status_regs_tb.sv
`timescale 1ns/1ps
module mdm_status_regs_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic loop_en = 0;
  logic [3:0] loop_ctl = '0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic delta_pending;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mdm_status_regs u_dut (
    .clk(clk), .rst_n(rst_n), .pin_cts_n(cts_n), .pin_dsr_n(dsr_n),
    .pin_ri_n(ri_n), .pin_dcd_n(dcd_n), .loop_en(loop_en), .loop_ctl(loop_ctl),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .delta_pending(delta_pending));

  // {loop_en, loop_ctl[3:0], pins_n {dcd,ri,dsr,cts}, expected status}
  localparam logic [16:0] VEC [0:14] = '{
    {1'b0, 4'h0, 4'hF, 8'h00},
    {1'b0, 4'h0, 4'hE, 8'h11},
    {1'b0, 4'h0, 4'hE, 8'h10},
    {1'b0, 4'h0, 4'hB, 8'h41},
    {1'b0, 4'h0, 4'hF, 8'h04},
    {1'b0, 4'h0, 4'h5, 8'hAA},
    {1'b0, 4'h0, 4'hF, 8'h0A},
    {1'b1, 4'h0, 4'hF, 8'h00},
    {1'b1, 4'h1, 4'hF, 8'h22},
    {1'b1, 4'h2, 4'hF, 8'h13},
    {1'b1, 4'h4, 4'hF, 8'h41},
    {1'b1, 4'h8, 4'hF, 8'h8C},
    {1'b1, 4'h8, 4'h0, 8'h80},
    {1'b0, 4'h8, 4'h0, 8'hF3},
    {1'b0, 4'h8, 4'hF, 8'h0F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_pins(input logic [3:0] p);
    {dcd_n, ri_n, dsr_n, cts_n} = p;
  endtask

  // one-cycle read at a falling edge; data sampled before the rising edge
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    reg_addr = a; reg_wdata = v; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7 reset state
    rd(3'd0, d); check("R7 status reset", d, 32'h0);
    rd(3'd1, d); check("R7 scratch reset", d, 32'h0);
    check("R9 pending after reset", {31'b0, delta_pending}, 32'h0);

    // table walk: R1 R2 R3 R4 R6
    for (int i = 0; i < 15; i++) begin
      loop_en = VEC[i][16]; loop_ctl = VEC[i][15:12]; set_pins(VEC[i][11:8]);
      repeat (4) @(negedge clk);
      check("R9 pending before read", {31'b0, delta_pending}, {31'b0, |VEC[i][3:0]});
      rd(3'd0, d);
      check("R1/R2/R3/R6 status vector", d, {24'b0, VEC[i][7:0]});
      check("R4 flags cleared, R9 pending low", {d[31:8], reg_rdata[7:4], delta_pending},
            {24'b0, VEC[i][7:4], 1'b0});
    end

    // R1/R2 timing through synchronizer, read strobe held on
    reg_addr = 3'd0; reg_rd = 1;
    set_pins(4'hE);
    @(negedge clk); check("R1 not after one edge", reg_rdata, 32'h00);
    @(negedge clk); check("R1 level after two edges", reg_rdata, 32'h10);
    @(negedge clk); check("R2 flag at third edge", reg_rdata, 32'h11);
    @(negedge clk); check("R4 cleared by held read", reg_rdata, 32'h10);
    reg_rd = 0;
    set_pins(4'hF);
    repeat (4) @(negedge clk);
    rd(3'd0, d); check("R2 cts release", d, 32'h01);

    // R5 event in the same cycle as the read
    loop_en = 1; loop_ctl = 4'h0;
    repeat (2) @(negedge clk);
    reg_addr = 3'd0; reg_rd = 1; loop_ctl = 4'h2;
    #1 check("R5 read returns old flags", {28'b0, reg_rdata[3:0]}, 32'h0);
    @(negedge clk); reg_rd = 0;
    check("R5 flag kept after read", reg_rdata, 32'h11);
    rd(3'd0, d);

    // R8 scratch, R4 non-status read keeps flags, R10 status write ignored
    wr(3'd1, 8'hA5);
    rd(3'd1, d); check("R8 scratch readback", d, 32'hA5);
    loop_ctl = 4'h1;
    repeat (2) @(negedge clk);
    rd(3'd1, d); check("R8 scratch unchanged", d, 32'hA5);
    wr(3'd0, 8'hFF);
    rd(3'd0, d); check("R4/R10 flags kept through scratch read and status write", d, 32'h23);
    wr(3'd0, 8'h0F);
    rd(3'd0, d); check("R10 status write ignored", d, 32'h20);
    wr(3'd5, 8'h3C);
    rd(3'd5, d); check("R7 unmapped reads zero", d, 32'h0);
    rd(3'd1, d); check("R8 scratch after unmapped write", d, 32'hA5);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule